// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block is a clocked lock controller. It keeps three programmable code digits of `DIGIT_W` bits each and checks digits typed in one at a time against them, in order. A digit is presented on `key_val` and marked by a single-cycle pulse on `key_stb`. The same value bus is used to program the code. Each of the three code slots has its own bit in `slot_load`, and a slot captures `key_val` on the clock edge where its bit is high.

Internally the controller has five states. Three of them wait for the first, second and third digit. The other two are an unlocked state and a sticky error state. The current waiting state steers a multiplexer that picks which stored digit is compared. A correct digit moves the machine forward, and the third correct digit unlocks it. A wrong digit in any waiting state sends it to the error state, and only reset leaves that state.

The single output `unlocked` is a registered Moore output. It goes high on the edge that enters the unlocked state and is low in every other state.

Top module: `combo_lock`

## Requirements
- R1: `rst` is synchronous and active high. One edge with `rst` high returns the machine to the first-digit state with `unlocked` low. The stored code survives reset, so the same code opens the lock afterwards without being reloaded.
- R2: Slot k (k = 0, 1, 2; slot 0 is the first digit) captures `key_val` only on an edge where `slot_load[k]` is 1. The other slots keep their values.
- R3: In the waiting state for digit k, a strobe whose value equals slot k advances to digit k+1. A matching strobe for the third digit makes `unlocked` read 1 from that same clock edge.
- R4: In any waiting state, a strobe whose value differs from the selected slot enters the error state. After that, the remaining correct digits leave `unlocked` at 0.
- R5: A cycle without a strobe changes neither the state nor `unlocked`. Any number of idle cycles between digits does not alter the result.
- R6: Once unlocked, the controller ignores further strobes of any value, and `unlocked` stays at 1 until reset.
- R7: The error state ignores all strobes, including a complete correct code. Only reset leaves it, and after that reset the correct code opens the lock again.
- R8: When a strobe and a load of the slot being compared fall in the same cycle, the comparison uses the slot contents from before that edge. The newly loaded value applies from the next cycle on.
- R9: When reset and a strobe fall in the same cycle, reset wins and the strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the sequence state |
| key_val | input | DIGIT_W | Entered digit, also the write data for code slots |
| key_stb | input | 1 | One-cycle marker that `key_val` holds an entered digit |
| slot_load | input | 3 | Per-slot load enables for the stored code |
| unlocked | output | 1 | 1 while in the unlocked state, 0 otherwise |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is programming a code slot and comparing against that same slot. The bench raises the strobe together with the load bit of the slot under comparison. It uses a new value that differs from the old one, so the digit mismatches the old contents. The bench then judges the result by whether the rest of the code still opens the lock, and whether the new value opens it after reset.

The second pair is reset and a strobe. The bench presents the correct third digit in the same cycle as reset. The lock must stay closed and must be back at the first digit.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int SLOTS = 3;
    localparam int ST_W  = 3;

    typedef enum logic [ST_W-1:0] {
        ST_D0   = 3'd0,
        ST_D1   = 3'd1,
        ST_D2   = 3'd2,
        ST_OPEN = 3'd3,
        ST_ERR  = 3'd4
    } lock_st_e;

    typedef struct packed {
        lock_st_e st;
        logic     opened;
    } fsm_t;

    function automatic logic is_check(input lock_st_e s);
        return (s == ST_D0) || (s == ST_D1) || (s == ST_D2);
    endfunction

endpackage

// File: rtl/code_store.sv
module code_store
    import lock_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic                       clk,
    input  logic [SLOTS-1:0]           slot_load,
    input  logic [DIGIT_W-1:0]         wr_val,
    output logic [SLOTS*DIGIT_W-1:0]   code_flat
);

    logic [DIGIT_W-1:0] slot_d [SLOTS];
    logic [DIGIT_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (slot_load[g]) begin
                slot_d[g] = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            slot_q[g] <= slot_d[g];
        end

        assign code_flat[g*DIGIT_W +: DIGIT_W] = slot_q[g];
    end

endmodule

// File: rtl/digit_mux.sv
module digit_mux
    import lock_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  lock_st_e                   st,
    input  logic [SLOTS*DIGIT_W-1:0]   code_flat,
    output logic [DIGIT_W-1:0]         sel_digit
);

    always_comb begin
        sel_digit = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (st == lock_st_e'(i)) begin
                sel_digit = code_flat[i*DIGIT_W +: DIGIT_W];
            end
        end
    end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               key_stb,
    input  logic [DIGIT_W-1:0] key_val,
    input  logic [DIGIT_W-1:0] sel_digit,
    output lock_st_e           st_q,
    output logic               open_q
);

    fsm_t cur_q;
    fsm_t nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (rst) begin
            nxt_d.st = ST_D0;
        end else if (is_check(cur_q.st) && key_stb) begin
            if (key_val != sel_digit) begin
                nxt_d.st = ST_ERR;
            end else if (cur_q.st == ST_D2) begin
                nxt_d.st = ST_OPEN;
            end else begin
                nxt_d.st = lock_st_e'(cur_q.st + 3'd1);
            end
        end
        nxt_d.opened = (nxt_d.st == ST_OPEN);
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign st_q   = cur_q.st;
    assign open_q = cur_q.opened;

endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import lock_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DIGIT_W-1:0] key_val,
    input  logic               key_stb,
    input  logic [SLOTS-1:0]   slot_load,
    output logic               unlocked
);

    logic [SLOTS*DIGIT_W-1:0] code_flat;
    logic [DIGIT_W-1:0]       sel_digit;
    lock_st_e                 st_q;

    code_store #(.DIGIT_W(DIGIT_W)) store_i (
        .clk       (clk),
        .slot_load (slot_load),
        .wr_val    (key_val),
        .code_flat (code_flat)
    );

    digit_mux #(.DIGIT_W(DIGIT_W)) mux_i (
        .st        (st_q),
        .code_flat (code_flat),
        .sel_digit (sel_digit)
    );

    lock_fsm #(.DIGIT_W(DIGIT_W)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .key_stb   (key_stb),
        .key_val   (key_val),
        .sel_digit (sel_digit),
        .st_q      (st_q),
        .open_q    (unlocked)
    );

endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
    import lock_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [DIGIT_W-1:0]       key_val,
    input logic                     key_stb,
    input logic [SLOTS-1:0]         slot_load,
    input logic                     unlocked,
    input lock_st_e                 st_q,
    input logic [DIGIT_W-1:0]       sel_digit,
    input logic [SLOTS*DIGIT_W-1:0] code_flat
);

    p_reset_home_r1: assert property (@(posedge clk)
        rst |=> (st_q == ST_D0) && !unlocked);

    for (genvar g = 0; g < SLOTS; g++) begin : g_hold
        p_slot_hold_r2: assert property (@(posedge clk)
            !slot_load[g] |=> $stable(code_flat[g*DIGIT_W +: DIGIT_W]));
    end

    p_first_step_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_D0 && key_stb && key_val == sel_digit) |=> st_q == ST_D1);

    p_last_opens_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_D2 && key_stb && key_val == sel_digit) |=> unlocked);

    p_mismatch_err_r4: assert property (@(posedge clk) disable iff (rst)
        (is_check(st_q) && key_stb && key_val != sel_digit) |=> st_q == ST_ERR);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !key_stb |=> $stable(st_q) && $stable(unlocked));

    p_open_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        unlocked |=> unlocked);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ERR) |=> (st_q == ST_ERR) && !unlocked);

endmodule

bind combo_lock combo_lock_chk #(.DIGIT_W(DIGIT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .key_val   (key_val),
    .key_stb   (key_stb),
    .slot_load (slot_load),
    .unlocked  (unlocked),
    .st_q      (st_q),
    .sel_digit (sel_digit),
    .code_flat (code_flat)
);

// File: tb/combo_lock_tb_top.sv
module combo_lock_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] key_val = '0;
    logic          key_stb = 1'b0;
    logic [2:0]    slot_load = '0;
    logic          unlocked;

    int checks = 0;
    int errors = 0;

    combo_lock #(.DIGIT_W(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .key_val   (key_val),
        .key_stb   (key_stb),
        .slot_load (slot_load),
        .unlocked  (unlocked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic exp);
        checks++;
        if (unlocked !== exp) begin
            errors++;
            $display("FAIL %s: unlocked=%0b expected %0b", req, unlocked, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic load(input int slot, input logic [DW-1:0] v);
        @(negedge clk); key_val = v; slot_load = 3'(1 << slot);
        @(negedge clk); slot_load = '0;
    endtask

    task automatic enter(input logic [DW-1:0] v);
        @(negedge clk); key_val = v; key_stb = 1'b1;
        @(negedge clk); key_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic program_code(input logic [DW-1:0] a, b, c);
        load(0, a); load(1, b); load(2, c);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 closed after reset", 1'b0);
    endtask

    task automatic t_correct();
        do_reset();
        enter(4'h3); chk("R3 first digit not open", 1'b0);
        enter(4'h9); chk("R3 second digit not open", 1'b0);
        enter(4'hC); chk("R3 third digit opens", 1'b1);
        enter(4'h0); chk("R6 wrong digit ignored when open", 1'b1);
        enter(4'h3); chk("R6 strobe ignored when open", 1'b1);
        idle(4);     chk("R6 open persists", 1'b1);
        do_reset();  chk("R1 reset closes", 1'b0);
        enter(4'h3); enter(4'h9); enter(4'hC);
        chk("R1 code kept through reset", 1'b1);
    endtask

    task automatic t_wrong_at(input int pos);
        logic [DW-1:0] code [3];
        code[0] = 4'h3; code[1] = 4'h9; code[2] = 4'hC;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            enter(i == pos ? (code[i] ^ 4'h1) : code[i]);
        end
        chk($sformatf("R4 wrong digit at slot %0d stays closed", pos), 1'b0);
        for (int i = 0; i < 3; i++) enter(code[i]);
        chk("R7 error ignores full correct code", 1'b0);
        do_reset();
        for (int i = 0; i < 3; i++) enter(code[i]);
        chk("R7 reset leaves error, code opens", 1'b1);
    endtask

    task automatic t_idle_gaps();
        do_reset();
        idle(3);
        enter(4'h3); idle(5); chk("R5 idle after first digit", 1'b0);
        enter(4'h9); idle(7); chk("R5 idle after second digit", 1'b0);
        enter(4'hC); chk("R5 opens despite gaps", 1'b1);
    endtask

    task automatic t_slot_independent();
        load(1, 4'h5);
        do_reset();
        enter(4'h3); enter(4'h9); enter(4'hC);
        chk("R2 old slot1 value rejected", 1'b0);
        do_reset();
        enter(4'h3); enter(4'h5); enter(4'hC);
        chk("R2 only slot1 changed", 1'b1);
        load(1, 4'h9);
    endtask

    task automatic t_load_collide();
        do_reset();
        @(negedge clk); key_val = 4'h7; key_stb = 1'b1; slot_load = 3'b001;
        @(negedge clk); key_stb = 1'b0; slot_load = '0;
        enter(4'h9); enter(4'hC);
        chk("R8 compare used old slot0 value", 1'b0);
        do_reset();
        enter(4'h7); enter(4'h9); enter(4'hC);
        chk("R8 new slot0 value applies after", 1'b1);
        load(0, 4'h3);
    endtask

    task automatic t_reset_wins();
        do_reset();
        enter(4'h3); enter(4'h9);
        @(negedge clk); rst = 1'b1; key_val = 4'hC; key_stb = 1'b1;
        @(negedge clk); rst = 1'b0; key_stb = 1'b0;
        chk("R9 reset beats strobe", 1'b0);
        enter(4'h3); enter(4'h9); enter(4'hC);
        chk("R9 back at first digit", 1'b1);
    endtask

    initial begin
        do_reset();
        program_code(4'h3, 4'h9, 4'hC);
        t_reset_state();
        t_correct();
        for (int p = 0; p < 3; p++) t_wrong_at(p);
        t_idle_gaps();
        t_slot_independent();
        t_load_collide();
        t_reset_wins();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog (all R): actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule